// File: doc/BRIEF.md
# SIMT Divergence Stack Controller

This block keeps the divergence stack of one warp in a SIMT core. Each stack entry holds a program counter, an active-lane mask and the program counter at which the lanes of that entry are expected to meet again (the reconvergence PC). The entry on top of the stack tells the fetch stage which PC to fetch next and which lanes take part. A PC value of zero is reserved to mean "none".

Once the warp has executed an instruction, the core presents one next-PC value and one finished flag per lane, together with the reconvergence PC of the instruction just executed. That reconvergence PC is computed elsewhere, and it applies to the first divergence found in the update. The block strips finished lanes from the top entry and splits the remaining lanes into groups that share a next PC. It handles one group per clock. Groups that have reached a reconvergence point are dropped, so the stack pops. Divergent groups are pushed above a rewritten reconvergence entry. The stack is seeded with one entry when a warp is launched.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the stack is empty: `stackDepth` is 0, `busy` and `updDone` are low, and `topPc`, `topMask` and `topRpc` are 0.
- R2: When idle, `launchValid` with a non-zero `launchMask` replaces the whole stack with a single entry {`launchPc`, `launchMask`, reconvergence PC 0}, giving depth 1 one cycle later. A launch with a zero mask, or any launch while `busy` is high, is ignored. When launch and update arrive together, the launch wins.
- R3: An update request while the stack is empty is ignored: `busy` stays low, no `updDone` pulse follows, and the depth stays 0.
- R4: An accepted update raises `busy` on the next cycle and keeps it high for exactly one cycle per extracted group, counting dropped groups and the empty group of an all-finished mask. `updDone` is high for one cycle, in the first cycle with `busy` low, and the new top is visible in that cycle.
- R5: Lane i takes its next PC from `nextPcIn[32*i+31:32*i]` and its finished flag from `laneDoneIn[i]`. The lane leading a group is the highest-numbered active, unfinished lane. Every other active, unfinished lane with the same next PC joins that group. Finished lanes and lanes outside the top mask join no group, and their next PCs have no effect.
- R6: A group whose PC equals the top entry's reconvergence PC is dropped. When every group is dropped, the top entry is popped and the depth falls by one.
- R7: The first kept group that leaves other live lanes behind marks divergence. If `reconvIn` differs from the top's reconvergence PC, the top entry's PC is rewritten to `reconvIn` (its mask and reconvergence PC stay) and the groups are pushed above it. Otherwise the first group overwrites the top entry. Pushed groups carry `reconvIn` as their reconvergence PC.
- R8: After divergence has been marked, a group whose PC equals `reconvIn` is dropped.
- R9: Without divergence, a single kept group replaces the top entry and inherits its reconvergence PC. The final top is the last entry written, in group order from the highest lane down.
- R10: The depth never exceeds 16 (twice the warp size). Writes past the last slot are discarded.
- R11: `topPc`, `topMask` and `topRpc` show the entry at index depth−1, and they are 0 while the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| launchValid | input | 1 | Seed the stack with one entry |
| launchPc | input | 32 | PC of the seed entry |
| launchMask | input | 8 | Lane mask of the seed entry |
| updValid | input | 1 | Start an update from the current lane results |
| nextPcIn | input | 256 | Per-lane next PC, lane i at bits 32*i+31:32*i |
| laneDoneIn | input | 8 | Per-lane finished flag |
| reconvIn | input | 32 | Reconvergence PC for the first divergence |
| busy | output | 1 | Update in progress |
| updDone | output | 1 | One-cycle pulse when the update has completed |
| topPc | output | 32 | PC of the top entry |
| topMask | output | 8 | Lane mask of the top entry |
| topRpc | output | 32 | Reconvergence PC of the top entry |
| stackDepth | output | 5 | Number of valid entries |

## Verification
Two writes can land in the same cycle on the first divergence: the top entry's PC is rewritten to the reconvergence point, and the first divergent group is pushed one slot above it. The bench causes this with two-way and three-way splits. It then pops the pushed groups one by one by sending their lanes to the reconvergence PC, and checks that the entry exposed underneath carries the rewritten PC with its original mask and reconvergence PC. The case where the new reconvergence PC equals the old one is run as well, and there the bench checks that no rewrite takes place and the first group takes over the top slot.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic launchLd;  // seed the stack with one entry
    logic start;     // latch lane results, begin an update
    logic step;      // process one group this cycle
    logic finish;    // last group: commit the new depth
  } rcsStrobe_t;

endpackage

// File: rtl/rcs_group_pick.sv
module rcs_group_pick #(
  parameter int LANES = 8,
  parameter int PCW   = 32
) (
  input  logic [LANES-1:0]     liveMask,
  input  logic [LANES*PCW-1:0] lanePcs,
  output logic                 grpValid,
  output logic [PCW-1:0]       grpPc,
  output logic [LANES-1:0]     grpMask,
  output logic [LANES-1:0]     restMask
);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LW-1:0] leader;

  // highest live lane leads the group
  always_comb begin
    leader = '0;
    for (int i = 0; i < LANES; i++) begin
      if (liveMask[i]) leader = LW'(i);
    end
  end

  assign grpValid = |liveMask;
  assign grpPc    = lanePcs[leader*PCW +: PCW];

  for (genvar g = 0; g < LANES; g++) begin : gMatch
    assign grpMask[g] = liveMask[g] && (lanePcs[g*PCW +: PCW] == grpPc);
  end

  assign restMask = liveMask & ~grpMask;

endmodule

// File: rtl/rcs_datapath.sv
module rcs_datapath
  import rcs_pkg::*;
#(
  parameter int LANES = 8,
  parameter int PCW   = 32,
  parameter int DEPTH = 2 * LANES,
  parameter int IDXW  = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rcsStrobe_t           stb,
  input  logic [PCW-1:0]       launchPc,
  input  logic [LANES-1:0]     launchMask,
  input  logic [LANES*PCW-1:0] nextPcIn,
  input  logic [LANES-1:0]     laneDoneIn,
  input  logic [PCW-1:0]       reconvIn,
  output logic [PCW-1:0]       topPc,
  output logic [LANES-1:0]     topMask,
  output logic [PCW-1:0]       topRpc,
  output logic [IDXW-1:0]      depthOut,
  output logic                 lastGroup,
  output logic                 stackEmpty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [IDXW-1:0] DEPTH_I = IDXW'(DEPTH);

  logic [PCW-1:0]   pcMem   [DEPTH];
  logic [LANES-1:0] maskMem [DEPTH];
  logic [PCW-1:0]   rpcMem  [DEPTH];

  logic [IDXW-1:0]      depthQ, wIdx;
  logic [LANES-1:0]     workMask, doneLat;
  logic [LANES*PCW-1:0] pcsLat;
  logic [PCW-1:0]       reconvLat, oldRpc, newRpc;
  logic                 diverged;

  // top-of-stack read
  logic [IDXW-1:0] topIdx;
  assign topIdx     = depthQ - IDXW'(1);
  assign stackEmpty = (depthQ == '0);
  assign depthOut   = depthQ;
  assign topPc      = stackEmpty ? '0 : pcMem[topIdx[AW-1:0]];
  assign topMask    = stackEmpty ? '0 : maskMem[topIdx[AW-1:0]];
  assign topRpc     = stackEmpty ? '0 : rpcMem[topIdx[AW-1:0]];

  // group extraction
  logic                 grpValid;
  logic [PCW-1:0]       grpPc;
  logic [LANES-1:0]     grpMask, restMask, liveMask;

  assign liveMask = workMask & ~doneLat;

  rcs_group_pick #(.LANES(LANES), .PCW(PCW)) u_pick (
    .liveMask (liveMask),
    .lanePcs  (pcsLat),
    .grpValid (grpValid),
    .grpPc    (grpPc),
    .grpMask  (grpMask),
    .restMask (restMask)
  );

  assign lastGroup = (restMask == '0);

  // per-group decisions
  logic            keepA, divNow, effDiv, rewrite, keepB;
  logic [PCW-1:0]  effRpc, pushRpc;
  logic [IDXW-1:0] idxPush, idxNext, depthNew;

  always_comb begin
    keepA    = grpValid && (grpPc != oldRpc);
    divNow   = keepA && !lastGroup && !diverged;
    effDiv   = diverged || divNow;
    effRpc   = divNow ? reconvLat : newRpc;
    rewrite  = divNow && (reconvLat != oldRpc);
    idxPush  = wIdx + IDXW'(rewrite);
    keepB    = keepA && !(effDiv && (grpPc == effRpc));
    idxNext  = idxPush + IDXW'(keepB);
    pushRpc  = effDiv ? effRpc : oldRpc;
    depthNew = (idxNext > DEPTH_I) ? DEPTH_I : idxNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < DEPTH; e++) begin
        pcMem[e]   <= '0;
        maskMem[e] <= '0;
        rpcMem[e]  <= '0;
      end
      depthQ    <= '0;
      wIdx      <= '0;
      workMask  <= '0;
      doneLat   <= '0;
      pcsLat    <= '0;
      reconvLat <= '0;
      oldRpc    <= '0;
      newRpc    <= '0;
      diverged  <= 1'b0;
    end else begin
      if (stb.launchLd) begin
        pcMem[0]   <= launchPc;
        maskMem[0] <= launchMask;
        rpcMem[0]  <= '0;
        depthQ     <= IDXW'(1);
      end
      if (stb.start) begin
        pcsLat    <= nextPcIn;
        doneLat   <= laneDoneIn;
        reconvLat <= reconvIn;
        workMask  <= topMask;
        oldRpc    <= topRpc;
        wIdx      <= topIdx;
        diverged  <= 1'b0;
        newRpc    <= '0;
      end
      if (stb.step) begin
        if (rewrite && (wIdx < DEPTH_I)) begin
          pcMem[wIdx[AW-1:0]] <= reconvLat;
        end
        if (keepB && (idxPush < DEPTH_I)) begin
          pcMem[idxPush[AW-1:0]]   <= grpPc;
          maskMem[idxPush[AW-1:0]] <= grpMask;
          rpcMem[idxPush[AW-1:0]]  <= pushRpc;
        end
        wIdx     <= idxNext;
        workMask <= restMask;
        diverged <= effDiv;
        newRpc   <= effRpc;
      end
      if (stb.finish) begin
        depthQ <= depthNew;
      end
    end
  end

endmodule

// File: rtl/rcs_control.sv
module rcs_control
  import rcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       launchValid,
  input  logic       launchMaskNz,
  input  logic       updValid,
  input  logic       stackEmpty,
  input  logic       lastGroup,
  output rcsStrobe_t stb,
  output logic       busy,
  output logic       updDone
);
  typedef enum logic {CS_IDLE, CS_RUN} ctlState_t;

  ctlState_t state;
  logic      doneQ;

  always_comb begin
    stb          = '0;
    stb.launchLd = (state == CS_IDLE) && launchValid && launchMaskNz;
    stb.start    = (state == CS_IDLE) && !stb.launchLd && updValid && !stackEmpty;
    stb.step     = (state == CS_RUN);
    stb.finish   = (state == CS_RUN) && lastGroup;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= CS_IDLE;
      doneQ <= 1'b0;
    end else begin
      doneQ <= stb.finish;
      if (stb.start)       state <= CS_RUN;
      else if (stb.finish) state <= CS_IDLE;
    end
  end

  assign busy    = (state == CS_RUN);
  assign updDone = doneQ;

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import rcs_pkg::*;
#(
  parameter int LANES = 8,
  parameter int PCW   = 32,
  localparam int DEPTH = 2 * LANES,
  localparam int IDXW  = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 launchValid,
  input  logic [PCW-1:0]       launchPc,
  input  logic [LANES-1:0]     launchMask,
  input  logic                 updValid,
  input  logic [LANES*PCW-1:0] nextPcIn,
  input  logic [LANES-1:0]     laneDoneIn,
  input  logic [PCW-1:0]       reconvIn,
  output logic                 busy,
  output logic                 updDone,
  output logic [PCW-1:0]       topPc,
  output logic [LANES-1:0]     topMask,
  output logic [PCW-1:0]       topRpc,
  output logic [IDXW-1:0]      stackDepth
);
  rcsStrobe_t stb;
  logic       lastGroup, stackEmpty;

  rcs_control u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .launchValid  (launchValid),
    .launchMaskNz (|launchMask),
    .updValid     (updValid),
    .stackEmpty   (stackEmpty),
    .lastGroup    (lastGroup),
    .stb          (stb),
    .busy         (busy),
    .updDone      (updDone)
  );

  rcs_datapath #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH), .IDXW(IDXW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .launchPc   (launchPc),
    .launchMask (launchMask),
    .nextPcIn   (nextPcIn),
    .laneDoneIn (laneDoneIn),
    .reconvIn   (reconvIn),
    .topPc      (topPc),
    .topMask    (topMask),
    .topRpc     (topRpc),
    .depthOut   (stackDepth),
    .lastGroup  (lastGroup),
    .stackEmpty (stackEmpty)
  );

endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
  parameter int LANES = 8,
  parameter int PCW   = 32,
  parameter int DEPTH = 2 * LANES,
  parameter int IDXW  = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             launchValid,
  input logic [PCW-1:0]   launchPc,
  input logic [LANES-1:0] launchMask,
  input logic             updValid,
  input logic             busy,
  input logic             updDone,
  input logic [PCW-1:0]   topPc,
  input logic [LANES-1:0] topMask,
  input logic [PCW-1:0]   topRpc,
  input logic [IDXW-1:0]  stackDepth
);
  logic launchTake;
  assign launchTake = launchValid && (launchMask != '0) && !busy;

  // R2
  launch_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    launchTake |=> (stackDepth == IDXW'(1)) && (topRpc == '0) &&
                   (topPc == $past(launchPc)) && (topMask == $past(launchMask)));

  // R3
  empty_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !launchTake && !busy && stackDepth == '0) |=> (!busy && stackDepth == '0));

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !launchTake && !busy && stackDepth != '0) |=> busy);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    updDone |-> !busy && $fell(busy));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    updDone |=> !updDone);

  // R4
  run_top_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (topMask != '0) && (stackDepth != '0) && $stable(stackDepth));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stackDepth <= IDXW'(DEPTH));

  // R11
  empty_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stackDepth == '0) |-> (topPc == '0) && (topMask == '0) && (topRpc == '0));

endmodule

bind simt_reconv_stack rcs_checker #(.LANES(LANES), .PCW(PCW)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .launchValid (launchValid),
  .launchPc    (launchPc),
  .launchMask  (launchMask),
  .updValid    (updValid),
  .busy        (busy),
  .updDone     (updDone),
  .topPc       (topPc),
  .topMask     (topMask),
  .topRpc      (topRpc),
  .stackDepth  (stackDepth)
);

// File: tb/simt_reconv_stack_tb.sv
module simt_reconv_stack_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN;
  logic         launchValid;
  logic [31:0]  launchPc;
  logic [7:0]   launchMask;
  logic         updValid;
  logic [255:0] nextPcIn;
  logic [7:0]   laneDoneIn;
  logic [31:0]  reconvIn;
  logic         busy, updDone;
  logic [31:0]  topPc, topRpc;
  logic [7:0]   topMask;
  logic [4:0]   stackDepth;

  int testsRun  = 0;
  int testsFail = 0;
  bit finished  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simt_reconv_stack u_dut (
    .clk(clk), .rstN(rstN), .launchValid(launchValid), .launchPc(launchPc),
    .launchMask(launchMask), .updValid(updValid), .nextPcIn(nextPcIn),
    .laneDoneIn(laneDoneIn), .reconvIn(reconvIn), .busy(busy), .updDone(updDone),
    .topPc(topPc), .topMask(topMask), .topRpc(topRpc), .stackDepth(stackDepth)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    testsRun++;
    if (act != exp) begin
      testsFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chkTop(input string req, input logic [31:0] pc, input logic [7:0] m,
                        input logic [31:0] rpc, input int depth);
    chk(req, "topPc", topPc, pc);
    chk(req, "topMask", topMask, m);
    chk(req, "topRpc", topRpc, rpc);
    chk(req, "depth", stackDepth, depth);
  endtask

  function automatic logic [255:0] pcs8(input logic [31:0] p7, p6, p5, p4, p3, p2, p1, p0);
    return {p7, p6, p5, p4, p3, p2, p1, p0};
  endfunction

  // one update; checks busy length and done pulse (R4)
  task automatic runUpd(input string req, input logic [255:0] pcs, input logic [7:0] dn,
                        input logic [31:0] rc, input int expCycles);
    int n = 0;
    nextPcIn = pcs; laneDoneIn = dn; reconvIn = rc; updValid = 1'b1;
    @(negedge clk);
    updValid = 1'b0;
    while (busy && n < 50) begin
      n++;
      @(negedge clk);
    end
    chk({req, " R4"}, "busy cycles", n, expCycles);
    chk({req, " R4"}, "updDone", updDone, 1);
  endtask

  task automatic doLaunch(input logic [31:0] pc, input logic [7:0] m);
    launchPc = pc; launchMask = m; launchValid = 1'b1;
    @(negedge clk);
    launchValid = 1'b0;
  endtask

  task automatic testReset();
    chkTop("R1", 0, 0, 0, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "updDone", updDone, 0);
  endtask

  task automatic testEmptyIgnore(input string tag);
    updValid = 1'b1; nextPcIn = '1; laneDoneIn = '0; reconvIn = 32'h77;
    @(negedge clk);
    updValid = 1'b0;
    chk(tag, "busy", busy, 0);
    @(negedge clk);
    chk(tag, "updDone", updDone, 0);
    chk(tag, "depth", stackDepth, 0);
  endtask

  task automatic testLaunch();
    doLaunch(32'h100, 8'hFF);
    chkTop("R2 launch", 32'h100, 8'hFF, 0, 1);
  endtask

  task automatic testUniform();
    runUpd("R9 uniform", {8{32'h104}}, 8'h00, 32'h200, 1);
    chkTop("R9 uniform", 32'h104, 8'hFF, 0, 1);
  endtask

  task automatic testTwoWay();
    runUpd("R7 two-way", pcs8(32'h140, 32'h140, 32'h140, 32'h140,
                              32'h180, 32'h180, 32'h180, 32'h180), 8'h00, 32'h200, 2);
    chkTop("R7 two-way", 32'h180, 8'h0F, 32'h200, 3);
    // lanes 7..4 carry bogus PCs: outside the top mask (R5)
    runUpd("R6 pop", pcs8(32'h999, 32'h998, 32'h997, 32'h996,
                          32'h200, 32'h200, 32'h200, 32'h200), 8'h00, 32'h555, 1);
    chkTop("R6 R5 pop", 32'h140, 8'hF0, 32'h200, 2);
  endtask

  task automatic testDoneLanes();
    runUpd("R5 done", pcs8(32'h300, 32'h300, 32'h144, 32'h144, 0, 0, 0, 0),
           8'hC0, 32'h444, 1);
    chkTop("R5 done", 32'h144, 8'h30, 32'h200, 2);
    runUpd("R6 pop2", pcs8(0, 0, 32'h200, 32'h200, 0, 0, 0, 0), 8'h00, 32'h444, 1);
    // rewritten entry from the two-way split (R7)
    chkTop("R7 rewritten entry", 32'h200, 8'hFF, 0, 1);
  endtask

  task automatic testThreeWay();
    runUpd("R7 three-way", pcs8(32'h210, 32'h210, 32'h220, 32'h220,
                                32'h230, 32'h230, 32'h230, 32'h230), 8'h00, 32'h300, 3);
    chkTop("R9 three-way order", 32'h230, 8'h0F, 32'h300, 4);
  endtask

  task automatic testSameRpc();
    runUpd("R7 same rpc", pcs8(0, 0, 0, 0, 32'h240, 32'h240, 32'h250, 32'h250),
           8'h00, 32'h300, 2);
    chkTop("R7 same rpc", 32'h250, 8'h03, 32'h300, 5);
  endtask

  task automatic testNewRpcDrop();
    runUpd("R8 drop", pcs8(0, 0, 0, 0, 0, 0, 32'h260, 32'h270), 8'h00, 32'h270, 2);
    chkTop("R8 drop", 32'h260, 8'h02, 32'h270, 6);
    runUpd("R6 pop3", pcs8(0, 0, 0, 0, 0, 0, 32'h270, 0), 8'h00, 32'h0, 1);
    chkTop("R8 rewrite seen", 32'h270, 8'h03, 32'h300, 5);
    runUpd("R5 all done", pcs8(0, 0, 0, 0, 0, 0, 32'h888, 32'h889), 8'h03, 32'h0, 1);
    chkTop("R5 all done pop", 32'h240, 8'h0C, 32'h300, 4);
  endtask

  task automatic testLaunchWhileBusy();
    int n = 0;
    nextPcIn = pcs8(0, 0, 0, 0, 32'h280, 32'h290, 0, 0);
    laneDoneIn = '0; reconvIn = 32'h2F0; updValid = 1'b1;
    @(negedge clk);
    updValid = 1'b0;
    launchPc = 32'hAAA; launchMask = 8'h01; launchValid = 1'b1;
    @(negedge clk);
    launchValid = 1'b0;
    while (busy && n < 50) begin
      n++;
      @(negedge clk);
    end
    chk("R2 busy launch", "updDone", updDone, 1);
    chkTop("R2 launch ignored", 32'h290, 8'h04, 32'h2F0, 6);
  endtask

  task automatic testDrain();
    runUpd("R6 drain", '0, 8'hFF, 32'h0, 1);
    chkTop("R6 drain", 32'h280, 8'h08, 32'h2F0, 5);
    runUpd("R6 drain", '0, 8'hFF, 32'h0, 1);
    chkTop("R7 drain rewrite", 32'h2F0, 8'h0C, 32'h300, 4);
    runUpd("R6 drain", '0, 8'hFF, 32'h0, 1);
    chkTop("R11 drain", 32'h220, 8'h30, 32'h300, 3);
    for (int k = 0; k < 3; k++) runUpd("R6 drain", '0, 8'hFF, 32'h0, 1);
    chkTop("R11 empty", 0, 0, 0, 0);
    doLaunch(32'h123, 8'h00);
    chk("R2 zero mask", "depth", stackDepth, 0);
    testEmptyIgnore("R3 after drain");
  endtask

  task automatic testLaunchWins();
    launchPc = 32'h500; launchMask = 8'hFF; launchValid = 1'b1;
    updValid = 1'b1; nextPcIn = '0; laneDoneIn = 8'hFF;
    @(negedge clk);
    launchValid = 1'b0; updValid = 1'b0;
    chk("R2 priority", "busy", busy, 0);
    chkTop("R2 priority", 32'h500, 8'hFF, 0, 1);
    runUpd("R5 half done", pcs8(32'h504, 32'h504, 32'h504, 32'h504, 1, 2, 3, 4),
           8'h0F, 32'h600, 1);
    chkTop("R5 half done", 32'h504, 8'hF0, 0, 1);
  endtask

  initial begin
    rstN = 1'b0; launchValid = 1'b0; launchPc = '0; launchMask = '0;
    updValid = 1'b0; nextPcIn = '0; laneDoneIn = '0; reconvIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEmptyIgnore("R3");
    testLaunch();
    testUniform();
    testTwoWay();
    testDoneLanes();
    testThreeWay();
    testSameRpc();
    testNewRpcDrop();
    testLaunchWhileBusy();
    testDrain();
    testLaunchWins();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

endmodule